// File: doc/BRIEF.md
# Overheat Threshold Monitor with Hysteresis

This block watches a stream of temperature codes from whichever sensor channel is currently selected upstream. Codes are unsigned, and a larger code means a hotter die. Software programs a threshold code and a two-bit hysteresis code. From these the block derives a high watermark above the threshold and a low watermark below it. The half-width of the band grows by powers of two with the hysteresis code.

A two-state tracker starts armed. It trips when a valid code reaches the high watermark and re-arms only when a valid code drops below the low watermark. When the tracker trips and the control-level interrupt enable is set, a sticky cause bit is latched. The interrupt line is that cause bit gated by a local mask bit and by a second-level aggregator enable.

Reading the cause register returns the bit. The read clears the bit only if the tracker is already armed again. A read made while the die is still hot leaves the bit set, so later overheat events are never lost. Register access is a single-cycle strobe interface with combinational read data.

Top module: `ovt_monitor`

## Requirements
- R1: The address map is as follows. Address 0 is control: threshold code in bits 12:3, hysteresis code in bits 20:19, interrupt enable in bit 25. Address 1 is the read-only cause register, with the cause bit in bit 20. Address 2 is the local mask, bit 20. Address 3 is the aggregator enable, bit 1. Every field reads back what was last written, and all other bits read 0.
- R2: With step = 4·2^h for hysteresis code h, the high watermark is min(threshold + step, 1023) and the low watermark is max(threshold − step, 0).
- R3: In the armed state, a valid code greater than or equal to the high watermark moves the tracker to tripped.
- R4: In the tripped state, a valid code below the low watermark moves the tracker back to armed. A code presented with the valid strobe low changes nothing.
- R5: The cause bit is set on the cycle after an armed-to-tripped move, but only when the interrupt enable is 1. It is never set otherwise.
- R6: A cause read while the tracker is tripped returns the bit and leaves it unchanged.
- R7: A cause read while the tracker is armed returns the bit and clears it on the next edge. If a trip happens in the same cycle, the set takes priority.
- R8: The interrupt output is high exactly when the cause bit, the mask bit and the aggregator enable are all 1.
- R9: After reset, the tracker is armed and the cause, mask, aggregator enable, interrupt enable and hysteresis are 0. The threshold is 1023 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample code valid strobe |
| smp_code | input | 10 | Temperature code of the selected channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the cause register when allowed) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| ovt_irq | output | 1 | Gated overheat interrupt |

## Verification
The hardest situations to reach are the ones where the cause bit must survive a read. One is a read made while the tracker is still tripped. The other is a threshold so low that the low watermark saturates at zero, which means the tracker can never re-arm. The bench sweeps every hysteresis code over thresholds near both ends of the code range. It ramps the code up through the high watermark and then down through the low one, issuing a cause read both mid-trip and after the fall. A separate step puts a read in the same cycle as a trip to exercise the priority of the set over the clear.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  typedef enum logic {ST_ARMED = 1'b0, ST_TRIPPED = 1'b1} ovt_state_e;
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_CAUSE = 2'd1;
  localparam logic [1:0] A_MASK  = 2'd2;
  localparam logic [1:0] A_AGG   = 2'd3;
endpackage

// File: rtl/ovt_regs.sv
module ovt_regs #(
  parameter int DATA_W    = 32,
  parameter int SAMP_W    = 10,
  parameter int HYS_W     = 2,
  parameter int THR_LSB   = 3,
  parameter int HYS_LSB   = 19,
  parameter int INTEN_BIT = 25,
  parameter int CAUSE_BIT = 20,
  parameter int AGG_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cause_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [SAMP_W-1:0] thr_q,
  output logic [HYS_W-1:0]  hys_q,
  output logic              inten_q,
  output logic              mask_q,
  output logic              agg_q,
  output logic              cause_rd
);
  import ovt_pkg::*;
  localparam logic [SAMP_W-1:0] THR_RST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= THR_RST;
      hys_q   <= '0;
      inten_q <= 1'b0;
      mask_q  <= 1'b0;
      agg_q   <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          thr_q   <= reg_wdata[THR_LSB +: SAMP_W];
          hys_q   <= reg_wdata[HYS_LSB +: HYS_W];
          inten_q <= reg_wdata[INTEN_BIT];
        end
        A_MASK:  mask_q <= reg_wdata[CAUSE_BIT];
        A_AGG:   agg_q  <= reg_wdata[AGG_BIT];
        default: ;
      endcase
    end
  end

  assign cause_rd = reg_rd && (reg_addr == A_CAUSE);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[THR_LSB +: SAMP_W] = thr_q;
        reg_rdata[HYS_LSB +: HYS_W]  = hys_q;
        reg_rdata[INTEN_BIT]         = inten_q;
      end
      A_CAUSE: reg_rdata[CAUSE_BIT] = cause_q;
      A_MASK:  reg_rdata[CAUSE_BIT] = mask_q;
      default: reg_rdata[AGG_BIT]   = agg_q;
    endcase
  end
endmodule

// File: rtl/ovt_watermark.sv
module ovt_watermark #(
  parameter int SAMP_W = 10,
  parameter int HYS_W  = 2
) (
  input  logic [SAMP_W-1:0] thr,
  input  logic [HYS_W-1:0]  hys,
  output logic [SAMP_W-1:0] wm_hi,
  output logic [SAMP_W-1:0] wm_lo
);
  localparam int SUM_W = SAMP_W + 1;
  localparam logic [SUM_W-1:0] CODE_MAX = {1'b0, {SAMP_W{1'b1}}};
  localparam logic [SUM_W-1:0] BASE_STEP = SUM_W'(4);

  function automatic logic [SUM_W-1:0] band_step(input logic [HYS_W-1:0] h);
    return BASE_STEP << h;
  endfunction

  function automatic logic [SAMP_W-1:0] high_mark(input logic [SAMP_W-1:0] t,
                                                  input logic [SUM_W-1:0] s);
    logic [SUM_W-1:0] sum;
    sum = {1'b0, t} + s;
    return (sum > CODE_MAX) ? CODE_MAX[SAMP_W-1:0] : sum[SAMP_W-1:0];
  endfunction

  function automatic logic [SAMP_W-1:0] low_mark(input logic [SAMP_W-1:0] t,
                                                 input logic [SUM_W-1:0] s);
    logic [SUM_W-1:0] dif;
    dif = {1'b0, t} - s;
    return ({1'b0, t} < s) ? '0 : dif[SAMP_W-1:0];
  endfunction

  logic [SUM_W-1:0] step;
  assign step  = band_step(hys);
  assign wm_hi = high_mark(thr, step);
  assign wm_lo = low_mark(thr, step);
endmodule

// File: rtl/ovt_tripfsm.sv
module ovt_tripfsm #(
  parameter int SAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [SAMP_W-1:0] smp_code,
  input  logic [SAMP_W-1:0] wm_hi,
  input  logic [SAMP_W-1:0] wm_lo,
  input  logic              inten,
  input  logic              cause_rd,
  output logic              tripped,
  output logic              cause_q,
  output logic              trip_evt,
  output logic              rearm_evt,
  output logic              clr_evt
);
  import ovt_pkg::*;
  ovt_state_e state_q;

  assign tripped   = (state_q == ST_TRIPPED);
  assign trip_evt  = smp_vld && !tripped && (smp_code >= wm_hi);
  assign rearm_evt = smp_vld &&  tripped && (smp_code <  wm_lo);
  assign clr_evt   = cause_rd && !tripped && !trip_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
    end else if (trip_evt) begin
      state_q <= ST_TRIPPED;
    end else if (rearm_evt) begin
      state_q <= ST_ARMED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
    end else if (trip_evt && inten) begin
      cause_q <= 1'b1;
    end else if (clr_evt) begin
      cause_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ovt_monitor.sv
module ovt_monitor #(
  parameter int DATA_W    = 32,
  parameter int SAMP_W    = 10,
  parameter int HYS_W     = 2,
  parameter int THR_LSB   = 3,
  parameter int HYS_LSB   = 19,
  parameter int INTEN_BIT = 25,
  parameter int CAUSE_BIT = 20,
  parameter int AGG_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [SAMP_W-1:0] smp_code,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ovt_irq
);
  logic [SAMP_W-1:0] thr_q, wm_hi, wm_lo;
  logic [HYS_W-1:0]  hys_q;
  logic inten_q, mask_q, agg_q, cause_q, cause_rd;
  logic fsm_tripped, trip_evt, rearm_evt, clr_evt;

  ovt_regs #(
    .DATA_W(DATA_W), .SAMP_W(SAMP_W), .HYS_W(HYS_W), .THR_LSB(THR_LSB),
    .HYS_LSB(HYS_LSB), .INTEN_BIT(INTEN_BIT), .CAUSE_BIT(CAUSE_BIT), .AGG_BIT(AGG_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cause_q(cause_q),
    .reg_rdata(reg_rdata), .thr_q(thr_q), .hys_q(hys_q), .inten_q(inten_q),
    .mask_q(mask_q), .agg_q(agg_q), .cause_rd(cause_rd)
  );

  ovt_watermark #(.SAMP_W(SAMP_W), .HYS_W(HYS_W)) u_wm (
    .thr(thr_q), .hys(hys_q), .wm_hi(wm_hi), .wm_lo(wm_lo)
  );

  ovt_tripfsm #(.SAMP_W(SAMP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
    .wm_hi(wm_hi), .wm_lo(wm_lo), .inten(inten_q), .cause_rd(cause_rd),
    .tripped(fsm_tripped), .cause_q(cause_q), .trip_evt(trip_evt),
    .rearm_evt(rearm_evt), .clr_evt(clr_evt)
  );

  assign ovt_irq = cause_q & mask_q & agg_q;
endmodule

// File: rtl/ovt_monitor_chk.sv
module ovt_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_vld,
  input logic tripped,
  input logic cause_q,
  input logic cause_rd,
  input logic trip_evt,
  input logic clr_evt,
  input logic inten,
  input logic agg,
  input logic irq
);
  // R6
  premature_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rd && tripped && cause_q) |=> cause_q);
  // R5
  trip_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_evt && inten) |=> cause_q);
  // R5
  no_spurious_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause_q && !trip_evt) |=> !cause_q);
  // R4
  idle_state_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(tripped));
  // R7
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !irq);
  // R8
  agg_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !agg |-> !irq);
endmodule

bind ovt_monitor ovt_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .tripped(fsm_tripped),
  .cause_q(cause_q), .cause_rd(cause_rd), .trip_evt(trip_evt),
  .clr_evt(clr_evt), .inten(inten_q), .agg(agg_q), .irq(ovt_irq)
);

// File: tb/ovt_monitor_test.sv
`timescale 1ns/1ps
module ovt_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [9:0] smp_code = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ovt_irq;

  int vectors = 0, fails = 0;
  bit done = 0;
  int b_thr = 1023, b_hys = 0;
  bit b_inten = 0, b_mask = 0, b_agg = 0;
  bit m_trip = 0, m_cause = 0;

  always #2 clk = ~clk;

  ovt_monitor uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovt_irq(ovt_irq)
  );

  task automatic chk(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hi_mark();
    int s = 4 * (1 << b_hys);
    return (b_thr + s > 1023) ? 1023 : b_thr + s;
  endfunction
  function automatic int lo_mark();
    int s = 4 * (1 << b_hys);
    return (b_thr - s < 0) ? 0 : b_thr - s;
  endfunction

  task automatic model_sample(int c);
    if (!m_trip && c >= hi_mark()) begin
      m_trip = 1;
      if (b_inten) m_cause = 1;
    end else if (m_trip && c < lo_mark()) m_trip = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
    case (a)
      2'd0: begin b_thr = d[12:3]; b_hys = d[20:19]; b_inten = d[25]; end
      2'd2: b_mask = d[20];
      2'd3: b_agg = d[1];
      default: ;
    endcase
  endtask

  task automatic set_ctrl(int thr, int h, bit en);
    wr(2'd0, (32'(thr) << 3) | (32'(h) << 19) | (32'(en) << 25));
  endtask

  task automatic sample(int c, bit vld);
    @(negedge clk);
    smp_vld = vld; smp_code = 10'(c);
    @(posedge clk); #1 smp_vld = 0;
    if (vld) model_sample(c);
  endtask

  task automatic check_irq(string req);
    @(negedge clk);
    chk(req, ovt_irq, m_cause & b_mask & b_agg);
  endtask

  task automatic rd_cause(string req, bit with_smp, int c);
    bit pre_trip;
    @(negedge clk);
    reg_rd = 1; reg_addr = 2'd1;
    if (with_smp) begin smp_vld = 1; smp_code = 10'(c); end
    #1 chk(req, reg_rdata, 32'(m_cause) << 20);
    @(posedge clk); #1 reg_rd = 0; smp_vld = 0;
    pre_trip = m_trip;
    if (with_smp) model_sample(c);
    if (!pre_trip && !(m_trip && !pre_trip)) m_cause = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    #3 rst_n = 1;
    b_thr = 1023; b_hys = 0; b_inten = 0; b_mask = 0; b_agg = 0;
    m_trip = 0; m_cause = 0;
  endtask

  task automatic rd_reg(string req, logic [1:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a; #1 chk(req, reg_rdata, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int thrs[4] = '{3, 100, 600, 1020};
    do_reset();
    // R9 reset state
    check_irq("R9");
    rd_reg("R9 ctrl", 2'd0, 32'h0000_1FF8);
    rd_reg("R9 mask", 2'd2, 0);
    rd_reg("R9 agg", 2'd3, 0);
    rd_cause("R9 cause", 0, 0);
    // R1 field placement and readback
    wr(2'd0, 32'hFFFF_FFFF);
    rd_reg("R1 ctrl", 2'd0, 32'h0218_1FF8);
    wr(2'd2, 32'hFFFF_FFFF);
    rd_reg("R1 mask", 2'd2, 32'h0010_0000);
    wr(2'd3, 32'hFFFF_FFFF);
    rd_reg("R1 agg", 2'd3, 32'h0000_0002);
    wr(2'd1, 32'hFFFF_FFFF);
    rd_cause("R1 cause ro", 0, 0);

    // R2 R3 R4 R6 R7 sweep over hysteresis codes and thresholds
    for (int h = 0; h < 4; h++) begin
      foreach (thrs[i]) begin
        int hi, lo, st;
        do_reset();
        wr(2'd2, 32'h0010_0000);
        wr(2'd3, 32'h2);
        set_ctrl(thrs[i], h, 1);
        hi = hi_mark(); lo = lo_mark();
        st = (lo - 3 < 0) ? 0 : lo - 3;
        for (int c = st; c <= ((hi + 2 > 1023) ? 1023 : hi + 2); c++) begin
          sample(c, 1);
          check_irq("R3");
        end
        rd_cause("R6 premature", 0, 0);
        check_irq("R6");
        for (int c = (hi + 2 > 1023) ? 1023 : hi + 2; c >= st; c--) begin
          sample(c, 1);
          check_irq("R4");
        end
        rd_cause("R7 after fall", 0, 0);
        check_irq("R7");
        rd_cause("R7 second read", 0, 0);
      end
    end

    // R4 invalid strobe ignored
    do_reset();
    wr(2'd2, 32'h0010_0000); wr(2'd3, 32'h2);
    set_ctrl(100, 0, 1);
    sample(1023, 0);
    check_irq("R4 invalid");
    rd_cause("R4 invalid", 0, 0);
    sample(103, 1);
    check_irq("R3 below hi");
    sample(104, 1);
    check_irq("R3 at hi");

    // R5 enable off: trip without cause
    do_reset();
    wr(2'd2, 32'h0010_0000); wr(2'd3, 32'h2);
    set_ctrl(200, 1, 0);
    sample(300, 1);
    check_irq("R5 disabled");
    rd_cause("R5 disabled", 0, 0);
    set_ctrl(200, 1, 1);
    sample(300, 1);
    check_irq("R5 still tripped");
    sample(100, 1);
    sample(300, 1);
    check_irq("R5 enabled");

    // R8 gating by mask and aggregator
    wr(2'd2, 0);
    check_irq("R8 mask");
    wr(2'd2, 32'h0010_0000);
    wr(2'd3, 0);
    check_irq("R8 agg");
    wr(2'd3, 32'h2);
    check_irq("R8 all on");

    // R7 same-cycle read and trip: set wins
    sample(100, 1);
    rd_cause("R7 clear", 0, 0);
    check_irq("R7 cleared");
    rd_cause("R7 read+trip", 1, 300);
    check_irq("R7 set wins");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule